// File: doc/BRIEF.md
# UART Byte Queue Pair with Programmable Thresholds

This block holds the receive and transmit byte queues of a serial port. It keeps two first-in first-out stores of equal depth. It reports how full each one is. It compares those fill counts against thresholds to produce a receive-service interrupt, a transmit-service interrupt and a flow-control permission flag. Serial framing, baud generation and host bus decoding sit outside the block.

A small write-only register port sets the thresholds. Each register is selected by a 3-bit address:

| Address | Setting |
|---|---|
| 0 | receive trigger |
| 1 | transmit trigger |
| 2 | flow-control low watermark |
| 3 | flow-control high watermark |
| 4 | mode register |

The mode register holds three fields:

- Bit 4 chooses between the freely programmed triggers and the coarse legacy codes.
- Bits 3:2 hold the legacy receive code.
- Bits 1:0 hold the legacy transmit code.

The framer pushes received bytes and the host pops them. The host pushes bytes for transmission and the serializer pops them. The flow flag tells the far end whether it may keep sending.

Top module: `uart_fifo_thresh`

## Requirements
- R1: Each queue holds up to DEPTH bytes. Its level output equals accepted pushes minus accepted pops. The level changes in the cycle after the clock edge that accepts the operation. A push is accepted when the level is below DEPTH. A pop is accepted when the level is above zero, even in the same cycle as a push.
- R2: Bytes leave each queue in the order they entered. The data output is registered: an accepted pop places the oldest byte on the output after that edge, and the output holds until the next accepted pop.
- R3: A push while the level equals DEPTH is dropped. The level and stored data stay unchanged, and the overrun output of that queue is high for exactly the one cycle after that edge.
- R4: A pop while the level is zero leaves the data output and the level unchanged, and raises no overrun.
- R5: The receive interrupt is high whenever the receive level is greater than or equal to the active receive threshold.
- R6: The transmit interrupt is high whenever the transmit level is less than or equal to the active transmit threshold.
- R7: With mode bit 4 set, the active thresholds are the values in registers 0 and 1, and the legacy code bits 3:0 have no effect.
- R8: With mode bit 4 clear, registers 0 and 1 have no effect. Receive code bits 3:2 values 0,1,2,3 select 1, DEPTH/4, DEPTH/2 and DEPTH-DEPTH/8. Transmit code bits 1:0 values 0,1,2,3 select DEPTH/8, DEPTH/4, DEPTH/2 and DEPTH-DEPTH/8.
- R9: Each edge updates the flow flag from the receive level held before that edge. When that level is at or above the high watermark, the flag goes low. Otherwise, when it is at or below the low watermark, the flag goes high. Otherwise the flag holds. The high watermark test takes priority.
- R10: A value above DEPTH written to any of registers 0 to 3 is stored as DEPTH. Writes to addresses 5 to 7 have no effect.
- R11: After reset both levels are 0, both data outputs are 0, both overrun outputs are low, the flow flag is high and the mode register is 0. Registers 0 to 3 hold 1, DEPTH/8, DEPTH/4 and DEPTH-DEPTH/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 3 | register select |
| cfg_wdata | input | LW | register write value |
| rx_push | input | 1 | store rx_din into the receive queue |
| rx_din | input | DW | received byte |
| rx_pop | input | 1 | take the oldest received byte |
| rx_dout | output | DW | last byte taken from the receive queue |
| tx_push | input | 1 | store tx_din into the transmit queue |
| tx_din | input | DW | byte to send |
| tx_pop | input | 1 | take the oldest byte to send |
| tx_dout | output | DW | last byte taken from the transmit queue |
| rx_level | output | LW | receive fill count |
| tx_level | output | LW | transmit fill count |
| rx_overrun | output | 1 | one-cycle pulse after a dropped receive push |
| tx_overrun | output | 1 | one-cycle pulse after a dropped transmit push |
| rx_irq | output | 1 | receive level has reached its trigger |
| tx_irq | output | 1 | transmit level is at or under its trigger |
| flow_go | output | 1 | high while the far end may keep sending |

## Verification
The following results appear one edge after their cause: levels, data outputs, overrun pulses and new register values. Both interrupts follow with no further delay, because they compare registered levels with registered thresholds. The flow flag also lands one edge after the receive level it was computed from, so it trails that level by one cycle. The bench drives inputs at the falling edge and updates its model at the rising edge. It compares every output one nanosecond after that rising edge. Its model computes the new flow flag from the pre-edge level before it applies the queue operations, which matches the one-cycle trail.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

   typedef enum logic [2:0] {
      REG_RX_TRIG = 3'd0,
      REG_TX_TRIG = 3'd1,
      REG_FC_LOW  = 3'd2,
      REG_FC_HIGH = 3'd3,
      REG_MODE    = 3'd4
   } cfg_reg_e;

   localparam int MODE_ARB_BIT = 4;

   // coarse receive thresholds selected by a 2-bit code
   function automatic int legacy_rx_level(input logic [1:0] code, input int depth);
      case (code)
         2'd0:    return 1;
         2'd1:    return depth / 4;
         2'd2:    return depth / 2;
         default: return depth - depth / 8;
      endcase
   endfunction

   // coarse transmit thresholds selected by a 2-bit code
   function automatic int legacy_tx_level(input logic [1:0] code, input int depth);
      case (code)
         2'd0:    return depth / 8;
         2'd1:    return depth / 4;
         2'd2:    return depth / 2;
         default: return depth - depth / 8;
      endcase
   endfunction

endpackage

// File: rtl/fifo_core.sv
module fifo_core #(
   parameter int DW    = 8,
   parameter int DEPTH = 128,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [LW-1:0] level,
   output logic          overrun
);

   initial begin
      if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0)
         $error("fifo_core: DEPTH must be a power of two of at least 16");
      if (DW < 1)
         $error("fifo_core: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          full, empty, take_in, take_out;

   assign full     = (level == LW'(DEPTH));
   assign empty    = (level == '0);
   assign take_in  = push && !full;
   assign take_out = pop && !empty;

   always_ff @(posedge clk) begin
      if (take_in)
         mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level   <= '0;
         dout    <= '0;
         overrun <= 1'b0;
      end else begin
         overrun <= push && full;
         if (take_in)
            wr_ptr <= wr_ptr + 1'b1;
         if (take_out) begin
            rd_ptr <= rd_ptr + 1'b1;
            dout   <= mem[rd_ptr];
         end
         level <= level + LW'(take_in) - LW'(take_out);
      end
   end

   assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop) |=> $stable(level));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (overrun && level == LW'(DEPTH)));

   assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> ($stable(dout) && level == '0 && !overrun));

endmodule

// File: rtl/thresh_regs.sv
module thresh_regs
   import uart_fifo_pkg::*;
#(
   parameter int DEPTH      = 128,
   parameter bit HAS_LEGACY = 1'b1,
   localparam int LW        = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [LW-1:0] cfg_wdata,
   output logic [LW-1:0] rx_thr,
   output logic [LW-1:0] tx_thr,
   output logic [LW-1:0] fc_low,
   output logic [LW-1:0] fc_high
);

   initial begin
      if (LW < 5)
         $error("thresh_regs: level width too small for the mode register");
   end

   localparam logic [LW-1:0] MAXV     = LW'(DEPTH);
   localparam logic [LW-1:0] RST_RX   = LW'(1);
   localparam logic [LW-1:0] RST_TX   = LW'(DEPTH / 8);
   localparam logic [LW-1:0] RST_LOW  = LW'(DEPTH / 4);
   localparam logic [LW-1:0] RST_HIGH = LW'(DEPTH - DEPTH / 8);

   logic [LW-1:0] arb_rx, arb_tx;
   logic [4:0]    mode_q;
   logic [LW-1:0] wval;

   assign wval = (cfg_wdata > MAXV) ? MAXV : cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arb_rx  <= RST_RX;
         arb_tx  <= RST_TX;
         fc_low  <= RST_LOW;
         fc_high <= RST_HIGH;
         mode_q  <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            REG_RX_TRIG: arb_rx  <= wval;
            REG_TX_TRIG: arb_tx  <= wval;
            REG_FC_LOW:  fc_low  <= wval;
            REG_FC_HIGH: fc_high <= wval;
            REG_MODE:    mode_q  <= cfg_wdata[4:0];
            default: ;
         endcase
      end
   end

   generate
      if (HAS_LEGACY) begin : g_legacy
         logic [LW-1:0] leg_rx, leg_tx;
         always_comb begin
            leg_rx = LW'(legacy_rx_level(mode_q[3:2], DEPTH));
            leg_tx = LW'(legacy_tx_level(mode_q[1:0], DEPTH));
         end
         assign rx_thr = mode_q[MODE_ARB_BIT] ? arb_rx : leg_rx;
         assign tx_thr = mode_q[MODE_ARB_BIT] ? arb_tx : leg_tx;
      end else begin : g_arb_only
         assign rx_thr = arb_rx;
         assign tx_thr = arb_tx;
      end
   endgenerate

   assert_thr_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_thr <= MAXV) && (tx_thr <= MAXV) && (fc_low <= MAXV) && (fc_high <= MAXV));

   assert_bad_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr > 3'd4) |=> ($stable(rx_thr) && $stable(tx_thr) &&
                                       $stable(fc_low) && $stable(fc_high)));

endmodule

// File: rtl/flow_ctl.sv
module flow_ctl #(
   parameter int DEPTH = 128,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] level,
   input  logic [LW-1:0] low_mark,
   input  logic [LW-1:0] high_mark,
   output logic          go
);

   logic at_high, at_low;

   assign at_high = (level >= high_mark);
   assign at_low  = (level <= low_mark);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         go <= 1'b1;
      else if (at_high)
         go <= 1'b0;
      else if (at_low)
         go <= 1'b1;
   end

   assert_fc_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      at_high |=> !go);

   assert_fc_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (at_low && !at_high) |=> go);

   assert_fc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!at_low && !at_high) |=> $stable(go));

endmodule

// File: rtl/uart_fifo_thresh.sv
module uart_fifo_thresh #(
   parameter int DW         = 8,
   parameter int DEPTH      = 128,
   parameter bit HAS_LEGACY = 1'b1,
   localparam int LW        = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [LW-1:0] cfg_wdata,
   input  logic          rx_push,
   input  logic [DW-1:0] rx_din,
   input  logic          rx_pop,
   output logic [DW-1:0] rx_dout,
   input  logic          tx_push,
   input  logic [DW-1:0] tx_din,
   input  logic          tx_pop,
   output logic [DW-1:0] tx_dout,
   output logic [LW-1:0] rx_level,
   output logic [LW-1:0] tx_level,
   output logic          rx_overrun,
   output logic          tx_overrun,
   output logic          rx_irq,
   output logic          tx_irq,
   output logic          flow_go
);

   logic [LW-1:0] rx_thr, tx_thr, fc_low, fc_high;

   fifo_core #(.DW(DW), .DEPTH(DEPTH)) u_rx_q (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din), .pop(rx_pop),
      .dout(rx_dout), .level(rx_level), .overrun(rx_overrun));

   fifo_core #(.DW(DW), .DEPTH(DEPTH)) u_tx_q (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_din), .pop(tx_pop),
      .dout(tx_dout), .level(tx_level), .overrun(tx_overrun));

   thresh_regs #(.DEPTH(DEPTH), .HAS_LEGACY(HAS_LEGACY)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .rx_thr(rx_thr), .tx_thr(tx_thr),
      .fc_low(fc_low), .fc_high(fc_high));

   flow_ctl #(.DEPTH(DEPTH)) u_flow (
      .clk(clk), .rst_n(rst_n), .level(rx_level), .low_mark(fc_low),
      .high_mark(fc_high), .go(flow_go));

   assign rx_irq = (rx_level >= rx_thr);
   assign tx_irq = (tx_level <= tx_thr);

   assert_rx_irq_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == LW'(DEPTH)) |-> rx_irq);

   assert_tx_irq_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level == '0) |-> tx_irq);

endmodule

// File: tb/tb_uart_fifo_thresh.sv
`timescale 1ns/1ps
module tb_uart_fifo_thresh;

   localparam int DW    = 8;
   localparam int DEPTH = 128;
   localparam int LW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [LW-1:0] cfg_wdata = '0;
   logic          rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
   logic [DW-1:0] rx_din = '0, tx_din = '0;
   logic [DW-1:0] rx_dout, tx_dout;
   logic [LW-1:0] rx_level, tx_level;
   logic          rx_overrun, tx_overrun, rx_irq, tx_irq, flow_go;

   always #2 clk = ~clk;

   uart_fifo_thresh #(.DW(DW), .DEPTH(DEPTH)) dut (.*);

   int n_vec = 0, n_bad = 0;
   int cyc = 0;
   bit wd_fired = 0;

   // reference model state
   int m_rx_trig, m_tx_trig, m_lo, m_hi, m_mode;
   int m_go;
   int q_data [2][DEPTH];
   int q_head [2];
   int q_cnt  [2];
   int q_dout [2];
   int q_ovr  [2];

   function automatic int leg_rx(input int c);
      case (c)
         0: return 1;
         1: return DEPTH / 4;
         2: return DEPTH / 2;
         default: return DEPTH - DEPTH / 8;
      endcase
   endfunction

   function automatic int leg_tx(input int c);
      case (c)
         0: return DEPTH / 8;
         1: return DEPTH / 4;
         2: return DEPTH / 2;
         default: return DEPTH - DEPTH / 8;
      endcase
   endfunction

   function automatic int eff_rx();
      return ((m_mode >> 4) & 1) ? m_rx_trig : leg_rx((m_mode >> 2) & 3);
   endfunction

   function automatic int eff_tx();
      return ((m_mode >> 4) & 1) ? m_tx_trig : leg_tx(m_mode & 3);
   endfunction

   function automatic int clampv(input int v);
      return (v > DEPTH) ? DEPTH : v;
   endfunction

   task automatic model_reset();
      m_rx_trig = 1; m_tx_trig = DEPTH / 8; m_lo = DEPTH / 4; m_hi = DEPTH - DEPTH / 8;
      m_mode = 0; m_go = 1;
      for (int i = 0; i < 2; i++) begin
         q_head[i] = 0; q_cnt[i] = 0; q_dout[i] = 0; q_ovr[i] = 0;
      end
   endtask

   task automatic model_q(input int k, input bit psh, input int d, input bit pp);
      bit ti, to;
      ti = psh && (q_cnt[k] < DEPTH);
      to = pp && (q_cnt[k] > 0);
      q_ovr[k] = psh && (q_cnt[k] == DEPTH);
      if (to) begin
         q_dout[k] = q_data[k][q_head[k]];
         q_head[k] = (q_head[k] + 1) % DEPTH;
         q_cnt[k]  = q_cnt[k] - 1;
      end
      if (ti) begin
         q_data[k][(q_head[k] + q_cnt[k]) % DEPTH] = d;
         q_cnt[k] = q_cnt[k] + 1;
      end
   endtask

   // advance the model by one edge, using inputs already driven
   task automatic model_step();
      if (q_cnt[0] >= m_hi) m_go = 0;
      else if (q_cnt[0] <= m_lo) m_go = 1;
      if (cfg_we) begin
         case (cfg_addr)
            3'd0: m_rx_trig = clampv(int'(cfg_wdata));
            3'd1: m_tx_trig = clampv(int'(cfg_wdata));
            3'd2: m_lo      = clampv(int'(cfg_wdata));
            3'd3: m_hi      = clampv(int'(cfg_wdata));
            3'd4: m_mode    = int'(cfg_wdata) & 31;
            default: ;
         endcase
      end
      model_q(0, rx_push, int'(rx_din), rx_pop);
      model_q(1, tx_push, int'(tx_din), tx_pop);
   endtask

   task automatic check(input string req, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      check({tag, " R1"}, "rx_level", int'(rx_level), q_cnt[0]);
      check({tag, " R1"}, "tx_level", int'(tx_level), q_cnt[1]);
      check({tag, " R2"}, "rx_dout", int'(rx_dout), q_dout[0]);
      check({tag, " R2"}, "tx_dout", int'(tx_dout), q_dout[1]);
      check({tag, " R3"}, "rx_overrun", int'(rx_overrun), q_ovr[0]);
      check({tag, " R3"}, "tx_overrun", int'(tx_overrun), q_ovr[1]);
      check({tag, " R5"}, "rx_irq", int'(rx_irq), int'(q_cnt[0] >= eff_rx()));
      check({tag, " R6"}, "tx_irq", int'(tx_irq), int'(q_cnt[1] <= eff_tx()));
      check({tag, " R9"}, "flow_go", int'(flow_go), m_go);
   endtask

   // inputs are set at the falling edge, compared 1 ns after the rising edge
   task automatic cycle(input string tag);
      model_step();
      @(posedge clk);
      #1;
      check_all(tag);
      @(negedge clk);
      cfg_we = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
   endtask

   task automatic cfg(input int a, input int v, input string tag);
      cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = LW'(v);
      cycle(tag);
   endtask

   task automatic ops(input bit rp, input bit rq, input bit tp, input bit tq, input string tag);
      rx_push = rp; rx_din = DW'($urandom); rx_pop = rq;
      tx_push = tp; tx_din = DW'($urandom); tx_pop = tq;
      cycle(tag);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 60000) begin
            wd_fired = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 60000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      model_reset();
      repeat (3) @(negedge clk);
      #1;
      check_all("reset R11");
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R4: pop on empty
      ops(0, 1, 0, 1, "empty pop R4");

      // R3 and R9: fill receive queue to overflow
      for (int i = 0; i < DEPTH + 3; i++) ops(1, 0, 1, 0, "fill R3 R9");
      ops(1, 1, 1, 1, "full push+pop R1");
      for (int i = 0; i < DEPTH; i++) ops(0, 1, 0, 1, "drain R2 R9");
      ops(0, 1, 0, 1, "drain empty R4");

      // R8: legacy codes, arbitrary registers ignored
      cfg(0, 77, "arb ignored R8");
      cfg(1, 90, "arb ignored R8");
      for (int c = 0; c < 16; c++) begin
         cfg(4, c, "legacy code R8");
         for (int i = 0; i < 8; i++) ops(1, 0, 1, 0, "legacy R8");
      end
      for (int i = 0; i < 130; i++) ops(0, 1, 0, 1, "drain R1");

      // R7: arbitrary mode, legacy code bits ignored
      cfg(4, 16 | 15, "arb mode R7");
      cfg(4, 16 | 5, "arb mode R7");
      for (int i = 0; i < 90; i++) ops(1, 0, 1, 0, "arb fill R7");

      // R10: clamp and unused addresses
      cfg(0, 200, "clamp R10");
      cfg(3, 255, "clamp R10");
      cfg(5, 3, "bad addr R10");
      cfg(7, 0, "bad addr R10");
      cfg(3, 100, "fc high R9");
      cfg(2, 20, "fc low R9");

      // random traffic with fill and drain phases
      for (int ph = 0; ph < 24; ph++) begin
         int bias;
         bias = (ph % 2 == 0) ? 75 : 25;
         for (int i = 0; i < 250; i++) begin
            if ($urandom_range(0, 99) < 4) begin
               int a, v;
               a = $urandom_range(0, 7);
               v = (a == 4) ? $urandom_range(0, 31) : $urandom_range(0, 160);
               cfg(a, v, "random cfg R7 R8 R10");
            end else begin
               ops($urandom_range(0, 99) < bias, $urandom_range(0, 99) >= bias,
                   $urandom_range(0, 99) >= bias, $urandom_range(0, 99) < bias,
                   "random R1 R2 R5 R6 R9");
            end
         end
      end

      if (!wd_fired) begin
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule